// File: doc/BRIEF.md
# Legacy Peripheral Chip-Select Decoder

This block sits beside a host-to-expansion bus bridge and turns each bus cycle into at most one active-low strobe for a legacy motherboard peripheral: the BIOS flash, the keyboard controller, the real-time clock, or the interrupt-controller register window. A cycle is described by its address, a read/write flag, a memory/I/O flag, a valid flag and its origin (host master or expansion-bus master). Every strobe is combinational from these inputs, qualified by a 16-bit control register that switches each decode on or off.

Any decoded cycle also enables the shared data transceiver and raises a forward-to-expansion flag. When a BIOS window near the top of the 4 GB space is decoded, the block overrides expansion address lines 23:20 with all ones, so the window appears at the top of the 16 MB expansion space.

The control register is written through a plain byte-enabled port and read back at all times. Bits 4 and 5 are stored but steer nothing in this block. Bits 3 and 15:9 are reserved.

Top module: `legacy_cs_decoder`

## Requirements
- R1: The control register resets to 0043h (RTC, keyboard and lower-BIOS decodes on). A write with cfg_be[0] updates bits 7:0 and one with cfg_be[1] updates bits 15:8 on the next clock. cfg_rdata shows the register at all times.
- R2: Bits 3 and 15:9 always read 0 and writes to them change nothing. The writable mask is 01F7h.
- R3: With bit 0 set, an I/O cycle (cyc_mem=0, cyc_addr[31:16]=0) to 0070h–0077h drives rtc_cs_n low and rtc_ale high. With bit 0 clear such a cycle drives neither.
- R4: With bit 1 set, an I/O cycle to exactly 0060h or 0064h drives kbd_cs_n low. With bit 1 clear, or at any neighbouring address, it stays high.
- R5: With bit 6 set, a memory cycle to 000E0000h–000EFFFFh or FFFE0000h–FFFEFFFFh from either master drives bios_cs_n low. With bit 6 clear these cycles are ignored.
- R6: With bit 7 set, a host-master memory cycle to FFF80000h–FFFDFFFFh drives bios_cs_n low. The same cycle from the expansion master is ignored.
- R7: With bit 2 clear, a write cycle to any BIOS window asserts nothing. With bit 2 set, writes decode like reads.
- R8: With bit 8 set, a host-master memory cycle to FEC00000h–FEC00003h or FEC00010h–FEC00013h drives apic_cs_n low. Expansion-master cycles never do, and with bit 8 clear the cycle is ignored.
- R9: When bios_cs_n is low and cyc_addr[31:24]=FFh, la_ovr_en is 1 and la_hi is 1111b. Otherwise la_ovr_en is 0 and la_hi is 0000b.
- R10: xcvr_oe_n is low and fwd_exp is high exactly when one of the chip selects is asserted.
- R11: With cyc_valid low every strobe is inactive. In every cycle at most one chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_be | input | 2 | Byte enables for cfg_wdata |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |
| cyc_valid | input | 1 | Current bus cycle is valid |
| cyc_addr | input | 32 | Cycle address |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_mem | input | 1 | 1 = memory, 0 = I/O |
| cyc_from_exp | input | 1 | 1 = expansion-bus master, 0 = host master |
| bios_cs_n | output | 1 | BIOS flash select, active low |
| kbd_cs_n | output | 1 | Keyboard controller select, active low |
| rtc_cs_n | output | 1 | Real-time clock select, active low |
| rtc_ale | output | 1 | Real-time clock address latch strobe, active high |
| apic_cs_n | output | 1 | Interrupt-controller window select, active low |
| xcvr_oe_n | output | 1 | Shared transceiver output enable, active low |
| fwd_exp | output | 1 | Cycle is forwarded to the expansion bus |
| la_ovr_en | output | 1 | Override expansion address lines 23:20 |
| la_hi | output | 4 | Override value for expansion address lines 23:20 |

## Verification
The sweep runs all 64 combinations of the six decode-enable bits. Each setting is driven with the first and last address of every window and the addresses one below and one above it, so an off-by-one edge or a swapped window shows up. Every address is tried as read and write, memory and I/O, and host and expansion origin. This separates the origin rules (extended BIOS and interrupt window are host-only) and the write-protect rule from plain address matching. Register tests with full, single-byte and all-ones writes show the byte enables working and the reserved bits staying at zero.

// File: rtl/lpcs_pkg.sv
package lpcs_pkg;

    localparam int CFG_W  = 16;
    localparam int CFG_BE = CFG_W / 8;
    localparam int ADDR_W = 32;
    localparam int IO_W   = 16;

    localparam logic [CFG_W-1:0] CFG_RESET = 16'h0043;
    localparam logic [CFG_W-1:0] CFG_MASK  = 16'h01F7;

    // control bit positions
    localparam int B_RTC     = 0;
    localparam int B_KBD     = 1;
    localparam int B_BIOS_WR = 2;
    localparam int B_MOUSE   = 4;
    localparam int B_FERR    = 5;
    localparam int B_LOWBIOS = 6;
    localparam int B_EXTBIOS = 7;
    localparam int B_APIC    = 8;

    // address windows
    localparam int NWIN       = 8;
    localparam int W_RTC      = 0;
    localparam int W_KBD60    = 1;
    localparam int W_KBD64    = 2;
    localparam int W_BLOW_1M  = 3;
    localparam int W_BLOW_4G  = 4;
    localparam int W_BEXT     = 5;
    localparam int W_APIC0    = 6;
    localparam int W_APIC1    = 7;

    localparam logic [ADDR_W-1:0] WIN_LO [NWIN] = '{
        32'h0000_0070, 32'h0000_0060, 32'h0000_0064, 32'h000E_0000,
        32'hFFFE_0000, 32'hFFF8_0000, 32'hFEC0_0000, 32'hFEC0_0010
    };
    localparam logic [ADDR_W-1:0] WIN_HI [NWIN] = '{
        32'h0000_0077, 32'h0000_0060, 32'h0000_0064, 32'h000E_FFFF,
        32'hFFFE_FFFF, 32'hFFFD_FFFF, 32'hFEC0_0003, 32'hFEC0_0013
    };

    typedef struct packed {
        logic apic_en;
        logic ext_bios_en;
        logic low_bios_en;
        logic bios_wr_en;
        logic kbd_en;
        logic rtc_en;
    } dec_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              mem;
        logic              from_exp;
    } bus_cyc_t;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_RTC  = 3'd1,
        TGT_KBD  = 3'd2,
        TGT_BIOS = 3'd3,
        TGT_APIC = 3'd4
    } target_e;

    function automatic dec_cfg_t cfg_view(input logic [CFG_W-1:0] c);
        dec_cfg_t v;
        v.apic_en     = c[B_APIC];
        v.ext_bios_en = c[B_EXTBIOS];
        v.low_bios_en = c[B_LOWBIOS];
        v.bios_wr_en  = c[B_BIOS_WR];
        v.kbd_en      = c[B_KBD];
        v.rtc_en      = c[B_RTC];
        return v;
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] lo,
                                       input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/lpcs_ctrl_reg.sv
module lpcs_ctrl_reg
    import lpcs_pkg::*;
#(
    parameter int               W     = CFG_W,
    parameter logic [W-1:0]     RESET = CFG_RESET,
    parameter logic [W-1:0]     MASK  = CFG_MASK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [W/8-1:0]   be,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);
    localparam int NB = W / 8;

    logic [W-1:0] q;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_byte
            always_ff @(posedge clk) begin
                if (rst)
                    q[b*8 +: 8] <= RESET[b*8 +: 8] & MASK[b*8 +: 8];
                else if (we && be[b])
                    q[b*8 +: 8] <= wdata[b*8 +: 8] & MASK[b*8 +: 8];
            end
        end
    endgenerate

    assign rdata = q;

    p_full_write_r1: assert property (@(posedge clk) disable iff (rst)
        (we && (&be)) |=> (rdata == ($past(wdata) & MASK)));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(rdata));

endmodule

// File: rtl/lpcs_window_bank.sv
module lpcs_window_bank
    import lpcs_pkg::*;
#(
    parameter int N  = NWIN,
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  hit
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_win
            assign hit[i] = in_window(addr, WIN_LO[i], WIN_HI[i]);
        end
    endgenerate
endmodule

// File: rtl/lpcs_target_select.sv
module lpcs_target_select
    import lpcs_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  bus_cyc_t       cyc,
    input  dec_cfg_t       cfg,
    input  logic [NWIN-1:0] hit,
    output target_e        tgt,
    output logic           top4g
);
    logic io_ok, mem_ok;
    logic rtc_sel, kbd_sel, bios_win, bios_sel, apic_sel;

    always_comb begin
        io_ok    = cyc.valid && !cyc.mem && (cyc.addr[ADDR_W-1:IO_W] == '0);
        mem_ok   = cyc.valid && cyc.mem;
        rtc_sel  = io_ok && cfg.rtc_en && hit[W_RTC];
        kbd_sel  = io_ok && cfg.kbd_en && (hit[W_KBD60] || hit[W_KBD64]);
        bios_win = mem_ok &&
                   ((cfg.low_bios_en && (hit[W_BLOW_1M] || hit[W_BLOW_4G])) ||
                    (cfg.ext_bios_en && !cyc.from_exp && hit[W_BEXT]));
        bios_sel = bios_win && (!cyc.write || cfg.bios_wr_en);
        apic_sel = mem_ok && !cyc.from_exp && cfg.apic_en &&
                   (hit[W_APIC0] || hit[W_APIC1]);

        if (rtc_sel)       tgt = TGT_RTC;
        else if (kbd_sel)  tgt = TGT_KBD;
        else if (bios_sel) tgt = TGT_BIOS;
        else if (apic_sel) tgt = TGT_APIC;
        else               tgt = TGT_NONE;

        top4g = (tgt == TGT_BIOS) && (cyc.addr[ADDR_W-1:24] == 8'hFF);
    end

    p_apic_host_only_r8: assert property (@(posedge clk) disable iff (rst)
        cyc.from_exp |-> (tgt != TGT_APIC));
    p_write_protect_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc.write && !cfg.bios_wr_en) |-> (tgt != TGT_BIOS));
    p_ext_host_only_r6: assert property (@(posedge clk) disable iff (rst)
        (cyc.from_exp && hit[W_BEXT]) |-> (tgt == TGT_NONE));

endmodule

// File: rtl/legacy_cs_decoder.sv
module legacy_cs_decoder
    import lpcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_BE-1:0] cfg_be,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_write,
    input  logic              cyc_mem,
    input  logic              cyc_from_exp,
    output logic              bios_cs_n,
    output logic              kbd_cs_n,
    output logic              rtc_cs_n,
    output logic              rtc_ale,
    output logic              apic_cs_n,
    output logic              xcvr_oe_n,
    output logic              fwd_exp,
    output logic              la_ovr_en,
    output logic [3:0]        la_hi
);
    logic [CFG_W-1:0] ctrl_q;
    logic [NWIN-1:0]  win_hit;
    bus_cyc_t         cyc;
    dec_cfg_t         dcfg;
    target_e          tgt;
    logic             top4g;

    lpcs_ctrl_reg #(.W(CFG_W), .RESET(CFG_RESET), .MASK(CFG_MASK)) u_ctrl (
        .clk(clk), .rst(rst), .we(cfg_we), .be(cfg_be),
        .wdata(cfg_wdata), .rdata(ctrl_q)
    );

    assign cfg_rdata = ctrl_q;
    assign dcfg      = cfg_view(ctrl_q);

    always_comb begin
        cyc.valid    = cyc_valid;
        cyc.addr     = cyc_addr;
        cyc.write    = cyc_write;
        cyc.mem      = cyc_mem;
        cyc.from_exp = cyc_from_exp;
    end

    lpcs_window_bank #(.N(NWIN), .AW(ADDR_W)) u_win (
        .addr(cyc_addr), .hit(win_hit)
    );

    lpcs_target_select u_sel (
        .clk(clk), .rst(rst), .cyc(cyc), .cfg(dcfg),
        .hit(win_hit), .tgt(tgt), .top4g(top4g)
    );

    always_comb begin
        rtc_cs_n  = (tgt != TGT_RTC);
        rtc_ale   = (tgt == TGT_RTC);
        kbd_cs_n  = (tgt != TGT_KBD);
        bios_cs_n = (tgt != TGT_BIOS);
        apic_cs_n = (tgt != TGT_APIC);
        xcvr_oe_n = (tgt == TGT_NONE);
        fwd_exp   = (tgt != TGT_NONE);
        la_ovr_en = top4g;
        la_hi     = top4g ? 4'hF : 4'h0;
    end

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> (bios_cs_n && kbd_cs_n && rtc_cs_n && apic_cs_n &&
                        !rtc_ale && xcvr_oe_n && !fwd_exp && !la_ovr_en));
    p_single_cs_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~bios_cs_n, ~kbd_cs_n, ~rtc_cs_n, ~apic_cs_n}));
    p_oe_tracks_cs_r10: assert property (@(posedge clk) disable iff (rst)
        xcvr_oe_n == (bios_cs_n && kbd_cs_n && rtc_cs_n && apic_cs_n));
    p_alias_r9: assert property (@(posedge clk) disable iff (rst)
        la_ovr_en |-> (!bios_cs_n && (cyc_addr[31:24] == 8'hFF) && (la_hi == 4'hF)));

endmodule

// File: tb/legacy_cs_decoder_tb.sv
module legacy_cs_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;
    logic        cyc_valid = 1'b0;
    logic [31:0] cyc_addr = 32'h0;
    logic        cyc_write = 1'b0;
    logic        cyc_mem = 1'b0;
    logic        cyc_from_exp = 1'b0;
    logic        bios_cs_n, kbd_cs_n, rtc_cs_n, rtc_ale, apic_cs_n;
    logic        xcvr_oe_n, fwd_exp, la_ovr_en;
    logic [3:0]  la_hi;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_cs_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_write(cyc_write),
        .cyc_mem(cyc_mem), .cyc_from_exp(cyc_from_exp),
        .bios_cs_n(bios_cs_n), .kbd_cs_n(kbd_cs_n), .rtc_cs_n(rtc_cs_n),
        .rtc_ale(rtc_ale), .apic_cs_n(apic_cs_n), .xcvr_oe_n(xcvr_oe_n),
        .fwd_exp(fwd_exp), .la_ovr_en(la_ovr_en), .la_hi(la_hi)
    );

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
            report();
        end
    end

    task automatic check_reg(input string req, input logic [15:0] exp);
        n_checks++;
        if (cfg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: cfg_rdata actual %h expected %h", req, cfg_rdata, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = 2'b00;
    endtask

    // output vector: {bios,kbd,rtc,ale,apic,oe_n,fwd,la_en,la_hi}
    function automatic logic [11:0] model(input logic [15:0] c, input logic v,
                                          input logic [31:0] a, input logic w,
                                          input logic m, input logic e);
        logic r, k, b, p, la;
        logic lowwin, extwin;
        r = v && !m && (a <= 32'h77) && (a >= 32'h70) && c[0];
        k = v && !m && (a == 32'h60 || a == 32'h64) && c[1];
        lowwin = (a >= 32'h000E0000 && a <= 32'h000EFFFF) ||
                 (a >= 32'hFFFE0000 && a <= 32'hFFFEFFFF);
        extwin = (a >= 32'hFFF80000 && a <= 32'hFFFDFFFF);
        b = v && m && ((c[6] && lowwin) || (c[7] && !e && extwin)) && (!w || c[2]);
        p = v && m && !e && c[8] &&
            ((a >= 32'hFEC00000 && a <= 32'hFEC00003) ||
             (a >= 32'hFEC00010 && a <= 32'hFEC00013));
        la = b && (a[31:24] == 8'hFF);
        return {!b, !k, !r, r, !p, !(r|k|b|p), (r|k|b|p), la, (la ? 4'hF : 4'h0)};
    endfunction

    function automatic string req_of(input logic [31:0] a, input logic m,
                                     input logic w, input logic v);
        if (!v) return "R11";
        if (!m && a[31:4] == 28'h7) return "R3";
        if (!m && a[31:4] == 28'h6) return "R4";
        if (m && a[31:24] == 8'hFE) return "R8";
        if (m && a >= 32'hFFF00000 && a < 32'hFFFE0000) return "R6";
        if (m && w) return "R7";
        if (m) return "R5";
        return "R10";
    endfunction

    task automatic run_cyc(input logic [15:0] c, input logic v, input logic [31:0] a,
                           input logic w, input logic m, input logic e);
        logic [11:0] exp, act;
        @(negedge clk);
        cyc_valid = v; cyc_addr = a; cyc_write = w; cyc_mem = m; cyc_from_exp = e;
        #1;
        exp = model(c, v, a, w, m, e);
        act = {bios_cs_n, kbd_cs_n, rtc_cs_n, rtc_ale, apic_cs_n,
               xcvr_oe_n, fwd_exp, la_ovr_en, la_hi};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (R9/R10 outputs incl.): cfg %h addr %h w%0d m%0d e%0d actual %b expected %b",
                     req_of(a, m, w, v), c, a, w, m, e, act, exp);
        end
    endtask

    logic [31:0] lo_t [8] = '{32'h70, 32'h60, 32'h64, 32'h000E0000,
                              32'hFFFE0000, 32'hFFF80000, 32'hFEC00000, 32'hFEC00010};
    logic [31:0] hi_t [8] = '{32'h77, 32'h60, 32'h64, 32'h000EFFFF,
                              32'hFFFEFFFF, 32'hFFFDFFFF, 32'hFEC00003, 32'hFEC00013};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reg("R1 reset", 16'h0043);

        wr_cfg(2'b11, 16'hFFFF);
        check_reg("R2 reserved", 16'h01F7);
        wr_cfg(2'b01, 16'h0000);
        check_reg("R1 low byte", 16'h0100);
        wr_cfg(2'b10, 16'h00FF);
        check_reg("R1 high byte", 16'h0000);
        wr_cfg(2'b00, 16'hFFFF);
        check_reg("R1 no byte enable", 16'h0000);
        wr_cfg(2'b11, 16'hFE08);
        check_reg("R2 reserved only", 16'h0000);

        for (int k = 0; k < 64; k++) begin
            logic [15:0] c;
            c = 16'h0;
            c[0] = k[0]; c[1] = k[1]; c[2] = k[2];
            c[6] = k[3]; c[7] = k[4]; c[8] = k[5];
            wr_cfg(2'b11, c);
            check_reg("R1 sweep", c);
            for (int wi = 0; wi < 8; wi++) begin
                for (int pt = 0; pt < 4; pt++) begin
                    logic [31:0] a;
                    case (pt)
                        0: a = lo_t[wi] - 1;
                        1: a = lo_t[wi];
                        2: a = hi_t[wi];
                        default: a = hi_t[wi] + 1;
                    endcase
                    for (int q = 0; q < 8; q++)
                        run_cyc(c, 1'b1, a, q[0], q[1], q[2]);
                end
            end
            run_cyc(c, 1'b0, 32'h70, 1'b0, 1'b0, 1'b0);
            run_cyc(c, 1'b0, 32'hFFFE0000, 1'b0, 1'b1, 1'b0);
            run_cyc(c, 1'b1, 32'h0001_0070, 1'b0, 1'b0, 1'b0);
        end

        done = 1;
        report();
    end
endmodule